// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM

A synthesizable model of a single-port synchronous static RAM. The data bus can change from a read to a write, and back, on every clock with no idle cycle in between. Every command input is sampled on the rising clock edge. Write data trails its command by the same number of enabled edges as read data does. In pipelined mode that is two edges, through an output register. In flow-through mode read data follows the address register directly, and write data is taken one edge after the command.

Each word has four 9-bit lanes, and each lane has its own active-low write strobe. A command starts only while the clock enable is low, all three chip selects are active and the load input is low. Holding the load input high runs a 4-beat burst on the two low address bits, in either linear or interleaved order. The data bus is split into an input, an output and an output-enable flag. The output-enable flag goes low immediately when the asynchronous output enable is raised.

Top module: `zt_sram`

## Requirements
- R1: With `pipe_mode` low, a read accepted at an enabled edge drives `dout` with the word at its address, and sets `dout_en`, in the cycle right after that edge.
- R2: With `pipe_mode` high, read data and `dout_en` appear after the next enabled edge following the read command.
- R3: A command is accepted only at an edge where `cen_n`=0 and `adv_ld`=0. If any of `sel1_n`=1, `sel2`=0 or `sel3_n`=1 holds at that edge, the slot is a deselect, and `dout_en` stays low for its data cycle.
- R4: An edge with `cen_n`=1 changes nothing: address, burst state, write pipeline, array and output register all hold, so `dout` and `dout_en` keep their values.
- R5: `we_n`=1 selects a read. On a write, `bw_n[i]`=0 writes lane i, which is `din[9*i+8:9*i]`, and the other lanes keep their value. `bw_n`=4'hF is a no-op write.
- R6: Write data is sampled from `din` at the second enabled edge after the command in pipelined mode, and at the first enabled edge after it in flow-through mode.
- R7: An enabled edge with `adv_ld`=1 repeats the previous slot's type (read, write or deselect) at the next burst address. The upper address bits are kept. With `interleave`=0, the two low bits are (start + beat) mod 4.
- R8: With `interleave`=1, the two low bits of each beat are the start bits XOR the beat count 1, 2, 3, then 0 again.
- R9: `oe_n`=1 forces `dout_en` low at once, without waiting for a clock edge.
- R10: In pipelined mode, a read of an address whose write is still in flight returns that write's enabled lanes merged over the array contents.
- R11: `dout_en` is low during the data cycles of writes and no-op writes.
- R12: While `rst_n` is low, and after its release until a read reaches its data cycle, `dout_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control pipeline |
| cen_n | input | 1 | Clock enable, active low |
| sel1_n | input | 1 | Chip select, active low |
| sel2 | input | 1 | Chip select, active high |
| sel3_n | input | 1 | Chip select, active low |
| adv_ld | input | 1 | 0 loads a new command, 1 advances the burst |
| we_n | input | 1 | 0 write, 1 read |
| bw_n | input | 4 | Per-lane write strobes, active low |
| addr | input | AW | Word address |
| pipe_mode | input | 1 | 1 pipelined, 0 flow-through; change only under reset |
| interleave | input | 1 | Burst order: 0 linear, 1 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| din | input | 36 | Write data |
| dout | output | 36 | Read data |
| dout_en | output | 1 | High when `dout` is driven onto the bus |

## Verification
The hardest case to reach is a pipelined read whose address matches a write that has been accepted but not yet committed. The match has to fall on exactly the edge where that write's data is on `din`, with partial strobes, and sometimes with clock-enable stalls in between. A directed write-then-read pair on one address covers the basic case. Random traffic then confines addresses to 16 words and mixes in stalls and bursts, so such collisions recur often under every mode and order. Every output is compared with a bench model that replays the command history and commits write data at the edge the latency rules call for.

// File: rtl/zt_sram_pkg.sv
`timescale 1ns/1ps
package zt_sram_pkg;
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;
endpackage

// File: rtl/zt_burst_addr.sv
`timescale 1ns/1ps
module zt_burst_addr (
    input  logic [1:0] start_lo,
    input  logic [1:0] beat,
    input  logic       interleave,
    output logic [1:0] beat_lo
);
    always_comb begin
        if (interleave) beat_lo = start_lo ^ beat;
        else            beat_lo = start_lo + beat;
    end
endmodule

// File: rtl/zt_lane_merge.sv
`timescale 1ns/1ps
module zt_lane_merge #(
    parameter int NL = 4,
    parameter int LW = 9,
    localparam int DW = NL * LW
) (
    input  logic [DW-1:0] base_word,
    input  logic [DW-1:0] new_word,
    input  logic [NL-1:0] take_n,
    output logic [DW-1:0] merged
);
    for (genvar i = 0; i < NL; i++) begin : g_lane
        assign merged[i*LW +: LW] = take_n[i] ? base_word[i*LW +: LW]
                                              : new_word[i*LW +: LW];
    end
endmodule

// File: rtl/zt_array.sv
`timescale 1ns/1ps
module zt_array #(
    parameter int AW = 10,
    parameter int NL = 4,
    parameter int LW = 9,
    localparam int DW = NL * LW,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [NL-1:0] wr_lane_n,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    for (genvar i = 0; i < NL; i++) begin : g_lane
        logic [LW-1:0] cells [DEPTH];
        always_ff @(posedge clk) begin
            if (wr_en && !wr_lane_n[i]) cells[wr_addr] <= wr_data[i*LW +: LW];
        end
        assign rd_data[i*LW +: LW] = cells[rd_addr];
    end
endmodule

// File: rtl/zt_sram.sv
`timescale 1ns/1ps
module zt_sram
    import zt_sram_pkg::*;
#(
    parameter int AW = 10,
    parameter int NL = 4,
    parameter int LW = 9,
    localparam int DW = NL * LW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cen_n,
    input  logic          sel1_n,
    input  logic          sel2,
    input  logic          sel3_n,
    input  logic          adv_ld,
    input  logic          we_n,
    input  logic [NL-1:0] bw_n,
    input  logic [AW-1:0] addr,
    input  logic          pipe_mode,
    input  logic          interleave,
    input  logic          oe_n,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          dout_en
);
    typedef struct packed {
        op_e           op;
        logic [AW-1:0] addr;
        logic [NL-1:0] bw_n;
    } slot_t;

    typedef struct packed {
        slot_t         s1;
        slot_t         s2;
        logic [AW-1:0] start;
        logic [1:0]    beat;
        logic [DW-1:0] out_word;
        logic          out_vld;
    } state_t;

    state_t q, d;

    logic          chip_on;
    logic [1:0]    beat_nxt;
    logic [1:0]    beat_lo;
    logic [DW-1:0] arr_rd;
    logic [DW-1:0] fwd_word;
    logic [NL-1:0] fwd_take_n;
    slot_t         commit;
    logic          commit_en;

    assign chip_on  = !sel1_n && sel2 && !sel3_n;
    assign beat_nxt = q.beat + 2'd1;

    zt_burst_addr u_burst (
        .start_lo   (q.start[1:0]),
        .beat       (beat_nxt),
        .interleave (interleave),
        .beat_lo    (beat_lo)
    );

    // write commit point: one slot deep in flow-through, two in pipelined
    assign commit    = pipe_mode ? q.s2 : q.s1;
    assign commit_en = !cen_n && (commit.op == OP_WRITE);

    zt_array #(.AW(AW), .NL(NL), .LW(LW)) u_array (
        .clk       (clk),
        .wr_en     (commit_en),
        .wr_addr   (commit.addr),
        .wr_data   (din),
        .wr_lane_n (commit.bw_n),
        .rd_addr   (q.s1.addr),
        .rd_data   (arr_rd)
    );

    // pending pipelined write on the same word overrides the array lanes
    assign fwd_take_n = (q.s2.op == OP_WRITE && q.s2.addr == q.s1.addr)
                        ? q.s2.bw_n : {NL{1'b1}};

    zt_lane_merge #(.NL(NL), .LW(LW)) u_merge (
        .base_word (arr_rd),
        .new_word  (din),
        .take_n    (fwd_take_n),
        .merged    (fwd_word)
    );

    always_comb begin
        d = q;
        if (!cen_n) begin
            if (!adv_ld) begin
                d.s1.op   = chip_on ? (we_n ? OP_READ : OP_WRITE) : OP_IDLE;
                d.s1.addr = addr;
                d.start   = addr;
                d.beat    = 2'd0;
            end else begin
                d.s1.op   = q.s1.op;
                d.s1.addr = {q.start[AW-1:2], beat_lo};
                d.beat    = beat_nxt;
            end
            d.s1.bw_n   = bw_n;
            d.s2        = q.s1;
            d.out_word  = fwd_word;
            d.out_vld   = (q.s1.op == OP_READ);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign dout    = pipe_mode ? q.out_word : arr_rd;
    assign dout_en = !oe_n && (pipe_mode ? q.out_vld : (q.s1.op == OP_READ));
endmodule

// File: rtl/zt_sram_chk.sv
`timescale 1ns/1ps
module zt_sram_chk #(
    parameter int AW = 10,
    parameter int NL = 4,
    parameter int LW = 9,
    localparam int DW = NL * LW
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cen_n,
    input logic          sel1_n,
    input logic          sel2,
    input logic          sel3_n,
    input logic          adv_ld,
    input logic          we_n,
    input logic [NL-1:0] bw_n,
    input logic [AW-1:0] addr,
    input logic          pipe_mode,
    input logic          interleave,
    input logic          oe_n,
    input logic [DW-1:0] din,
    input logic [DW-1:0] dout,
    input logic          dout_en
);
    logic sel_ok, new_cmd, rd_cmd;
    assign sel_ok  = !sel1_n && sel2 && !sel3_n;
    assign new_cmd = !cen_n && !adv_ld;
    assign rd_cmd  = new_cmd && sel_ok && we_n;

    assert_oe_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dout_en);

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cen_n |=> $stable(dout));

    assert_deselect_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (new_cmd && !sel_ok && !pipe_mode) |=> !dout_en);

    assert_write_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (new_cmd && sel_ok && !we_n && !pipe_mode) |=> !dout_en);

    assert_flow_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cmd && !pipe_mode) |=> (oe_n || dout_en));

    assert_pipe_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_mode && !oe_n && $past(!cen_n) && $past(!cen_n, 2) && $past(rd_cmd, 2))
        |-> dout_en);
endmodule

bind zt_sram zt_sram_chk #(.AW(AW), .NL(NL), .LW(LW)) u_chk (.*);

// File: tb/zt_sram_test.sv
`timescale 1ns/1ps
module zt_sram_test;
    localparam int AW = 10;
    localparam int NL = 4;
    localparam int LW = 9;
    localparam int DW = NL * LW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cen_n = 1'b1;
    logic          sel1_n = 1'b0;
    logic          sel2 = 1'b1;
    logic          sel3_n = 1'b0;
    logic          adv_ld = 1'b0;
    logic          we_n = 1'b1;
    logic [NL-1:0] bw_n = '1;
    logic [AW-1:0] addr = '0;
    logic          pipe_mode = 1'b0;
    logic          interleave = 1'b0;
    logic          oe_n = 1'b0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_en;

    int tests = 0;
    int fails = 0;
    string tag_ovr = "";

    always #2.5 clk = ~clk;

    zt_sram #(.AW(AW), .NL(NL), .LW(LW)) uut (.*);

    // bench model: op 0 deselect, 1 read, 2 write
    logic [DW-1:0] mref [16];
    int            h_op [3];
    logic [AW-1:0] h_addr [3];
    logic [NL-1:0] h_bw [3];
    bit            h_burst [3];
    logic [AW-1:0] b_start;
    logic [1:0]    b_beat;
    bit            exp_rd = 0;
    bit            exp_burst = 0;
    logic [DW-1:0] exp_data = '0;

    task automatic model_edge();
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) h_op[i] = 0;
            exp_rd = 0;
        end else if (!cen_n) begin
            int lat = pipe_mode ? 2 : 1;
            if (h_op[lat-1] == 2)
                for (int l = 0; l < NL; l++)
                    if (!h_bw[lat-1][l]) mref[h_addr[lat-1][3:0]][l*LW +: LW] = din[l*LW +: LW];
            for (int i = 2; i > 0; i--) begin
                h_op[i] = h_op[i-1]; h_addr[i] = h_addr[i-1];
                h_bw[i] = h_bw[i-1]; h_burst[i] = h_burst[i-1];
            end
            if (!adv_ld) begin
                h_op[0] = (!sel1_n && sel2 && !sel3_n) ? (we_n ? 1 : 2) : 0;
                h_addr[0] = addr; b_start = addr; b_beat = 2'd0; h_burst[0] = 0;
            end else begin
                logic [1:0] lo;
                b_beat = b_beat + 2'd1;
                lo = interleave ? (b_start[1:0] ^ b_beat) : (b_start[1:0] + b_beat);
                h_addr[0] = {b_start[AW-1:2], lo}; h_burst[0] = 1;
            end
            h_bw[0] = bw_n;
            exp_rd = (h_op[lat-1] == 1);
            exp_burst = h_burst[lat-1];
            if (exp_rd) exp_data = mref[h_addr[lat-1][3:0]];
        end
    endtask

    function automatic string pick_tag(bit drv);
        if (tag_ovr != "") return tag_ovr;
        if (!rst_n) return "R12";
        if (oe_n) return "R9";
        if (exp_rd && exp_burst) return interleave ? "R8" : "R7";
        if (exp_rd) return pipe_mode ? "R2" : "R1";
        if (!drv) return "R11";
        return "R3";
    endfunction

    task automatic check();
        bit drv = exp_rd && !oe_n && rst_n;
        string t = pick_tag(drv);
        tests++;
        if (dout_en !== drv) begin
            fails++;
            $display("FAIL %s dout_en actual %b expected %b", t, dout_en, drv);
        end else if (drv) begin
            tests++;
            if (dout !== exp_data) begin
                fails++;
                $display("FAIL %s dout actual %h expected %h", t, dout, exp_data);
            end
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check();
    endtask

    task automatic cmd(bit ce, bit ld, bit w, logic [NL-1:0] bw, logic [AW-1:0] a);
        cen_n = !ce; adv_ld = !ld; we_n = !w; bw_n = bw; addr = a;
        din = {$urandom, $urandom};
        cycle();
    endtask

    task automatic do_reset(bit pm, bit il);
        rst_n = 1'b0; cen_n = 1'b1; oe_n = 1'b0;
        pipe_mode = pm; interleave = il;
        sel1_n = 1'b0; sel2 = 1'b1; sel3_n = 1'b0;
        tag_ovr = "R12";
        cycle(); cycle();
        rst_n = 1'b1;
        cycle();
        tag_ovr = "";
    endtask

    task automatic rnd_cycle();
        cen_n  = ($urandom % 8 == 0);
        sel1_n = ($urandom % 10 == 0);
        sel2   = ($urandom % 10 != 0);
        sel3_n = ($urandom % 10 == 0);
        adv_ld = ($urandom % 3 == 0);
        we_n   = $urandom % 2;
        bw_n   = ($urandom % 4 == 0) ? 4'hF : NL'($urandom);
        addr   = AW'($urandom % 16);
        oe_n   = ($urandom % 12 == 0);
        din    = {$urandom, $urandom};
        cycle();
    endtask

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 3; i++) begin h_op[i] = 0; h_addr[i] = '0; h_bw[i] = '1; h_burst[i] = 0; end
        for (int i = 0; i < 16; i++) mref[i] = '0;
        b_start = '0; b_beat = '0;

        // R12: reset leaves the bus undriven
        do_reset(1'b0, 1'b0);

        // preload the 16 test words in flow-through mode
        for (int i = 0; i < 16; i++) cmd(1, 1, 1, 4'h0, AW'(i));
        cmd(1, 1, 0, 4'hF, 0);
        cmd(1, 1, 0, 4'hF, 0);

        // R5: partial lane write, then no-op write, then reads
        tag_ovr = "R5";
        cmd(1, 1, 1, 4'b1010, 5);
        cmd(1, 1, 1, 4'hF, 6);
        cmd(1, 1, 0, 4'hF, 5);
        cmd(1, 1, 0, 4'hF, 6);
        cmd(1, 1, 0, 4'hF, 0);
        // R6: flow write with a stall before its data edge
        tag_ovr = "R6";
        cmd(1, 1, 1, 4'h0, 8);
        cmd(0, 1, 0, 4'hF, 0);
        cmd(1, 1, 0, 4'hF, 8);
        cmd(1, 1, 0, 4'hF, 0);
        // R3: deselected read
        tag_ovr = "R3";
        sel2 = 1'b0;
        cmd(1, 1, 0, 4'hF, 3);
        sel2 = 1'b1;
        cmd(1, 1, 0, 4'hF, 3);
        // R9: output enable asynchronous
        tag_ovr = "R9";
        cmd(1, 1, 0, 4'hF, 4);
        #1 oe_n = 1'b1; #0.5;
        tests++;
        if (dout_en !== 1'b0) begin fails++; $display("FAIL R9 dout_en actual %b expected 0", dout_en); end
        oe_n = 1'b0; #0.5;
        tests++;
        if (dout_en !== 1'b1) begin fails++; $display("FAIL R9 dout_en actual %b expected 1", dout_en); end
        // R7: linear burst from low bits 01
        tag_ovr = "R7";
        cmd(1, 1, 0, 4'hF, 9);
        for (int i = 0; i < 4; i++) cmd(1, 0, 0, 4'hF, 0);

        // pipelined mode
        do_reset(1'b1, 1'b1);
        tag_ovr = "R10";
        cmd(1, 1, 1, 4'b0110, 7);
        cmd(1, 1, 0, 4'hF, 7);
        cmd(1, 1, 0, 4'hF, 7);
        cmd(1, 1, 0, 4'hF, 0);
        tag_ovr = "R6";
        cmd(1, 1, 1, 4'h0, 10);
        cmd(0, 1, 0, 4'hF, 0);
        cmd(1, 1, 0, 4'hF, 0);
        cmd(1, 1, 0, 4'hF, 10);
        cmd(1, 1, 0, 4'hF, 0);
        tag_ovr = "R4";
        cmd(1, 1, 0, 4'hF, 3);
        cmd(0, 1, 0, 4'hF, 0);
        cmd(0, 1, 0, 4'hF, 0);
        cmd(1, 1, 0, 4'hF, 0);
        cmd(0, 1, 0, 4'hF, 0);
        cmd(0, 1, 0, 4'hF, 0);
        tag_ovr = "R8";
        cmd(1, 1, 0, 4'hF, 9);
        for (int i = 0; i < 4; i++) cmd(1, 0, 0, 4'hF, 0);
        cmd(1, 1, 0, 4'hF, 0);
        tag_ovr = "R11";
        cmd(1, 1, 1, 4'h0, 2);
        cmd(1, 1, 1, 4'hF, 2);
        cmd(1, 1, 0, 4'hF, 0);
        tag_ovr = "";

        // random traffic under every mode and burst order
        for (int m = 0; m < 4; m++) begin
            do_reset(m[1], m[0]);
            for (int n = 0; n < 700; n++) rnd_cycle();
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        fails++;
        tests++;
        $display("FAIL watchdog run did not finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule